// File: doc/BRIEF.md
# Flash In-Application Programming Command Front-End

This block sits on the internal special-function-register bus of a microcontroller core. It holds the registers through which firmware starts operations on its own flash array. Firmware first sets the programming-enable bit in a configuration register. It then writes an operation code to a command register. The block checks the code and, if it is accepted, sends one start strobe on a dedicated line to an external flash sequencer. While the operation runs, the block holds a busy flag. When the sequencer returns its done pulse, the block raises a completion event.

The completion event can take over the core's interrupt-1 input. When the interrupt-enable bit in the command register is set, the core's interrupt-1 line carries the completion event and the real external pin is masked. When the bit is clear, the external pin passes straight through. Byte-verify is a short operation. It finishes one cycle after it is issued, needs no done pulse and never raises the completion event.

The configuration register also holds two map bits, which are loaded from two remap pins while reset is held. It also holds a visibility bit, which flags fetches into the top 4 KB of the address space.

The controller has four states:
- **IDLE**: accepts command writes.
- **VERIFY**: the one-cycle short operation.
- **RUN**: waits for the sequencer.
- **DONE**: the one-cycle completion slot.

Its transitions are:
- IDLE→VERIFY on an accepted byte-verify.
- IDLE→RUN on any other accepted code.
- VERIFY→IDLE always.
- RUN→DONE on the done pulse.
- DONE→IDLE always.

Top module: `flash_iap_frontend`

## Requirements
- R1: While reset is held and after it is released:
  - the configuration register reads as six zero bits above the two remap pin values sampled during reset;
  - the command register reads 0x00;
  - busy is 0 and no start strobe is active.
- R2: The configuration register is at SFR address 0xB1. Its fields are:
  - bit 7: upper-block visibility;
  - bit 6: programming enable;
  - bits 1:0: map bits;
  - bits 5:2: always read 0.
  
  The command register is at address 0xB2, with bit 7 as interrupt enable and bits 6:0 as operation code. Both registers read back on `sfr_rdata` combinationally from `sfr_addr`.
- R3: Each accepted valid code produces exactly one start strobe, one cycle wide, in the cycle after the write. The code-to-strobe-bit mapping is:

  | Code | Operation | `start_vec` bit |
  |------|-----------|-----------------|
  | 0x01 | chip erase | 0 |
  | 0x06 | burst program | 1 |
  | 0x0B | sector erase | 2 |
  | 0x0C | byte verify | 3 |
  | 0x0D | block erase | 4 |
  | 0x0E | byte program | 5 |

- R4: Any other code starts nothing and leaves busy at 0.
- R5: With programming enable at 0, no code starts anything.
- R6: For every valid code except byte-verify:
  - busy rises together with the strobe and stays high until `seq_done`;
  - it stays high for one more completion cycle after `seq_done`;
  - it then falls.
- R7: A command-register write made while busy is ignored completely: there is no strobe and the register keeps its value.
- R8: Byte-verify:
  - holds busy for exactly one cycle;
  - ignores `seq_done`;
  - never drives the interrupt line low, whatever the interrupt-enable bit.
- R9: With interrupt enable at 1, `int1_n_core` is:
  - low for exactly the one completion cycle of a long operation;
  - high otherwise, whatever `int1_n_ext` does.
- R10: With interrupt enable at 0, `int1_n_core` equals `int1_n_ext`.
- R11: `upper_visible` is 1 exactly when the visibility bit is 1 and `fetch_addr` lies in 0xF000–0xFFFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| remap_pins | input | 2 | Map bit values loaded during reset |
| sfr_addr | input | 8 | SFR bus address |
| sfr_wr | input | 1 | SFR write strobe |
| sfr_wdata | input | 8 | SFR write data |
| sfr_rdata | output | 8 | SFR read data for the addressed register |
| start_vec | output | 6 | One-hot operation start strobes to the sequencer |
| seq_done | input | 1 | Sequencer completion pulse |
| busy | output | 1 | Operation in progress |
| int1_n_ext | input | 1 | External interrupt-1 pin, active low |
| int1_n_core | output | 1 | Interrupt-1 line to the core, active low |
| fetch_addr | input | 16 | Instruction fetch address |
| upper_visible | output | 1 | Fetch falls in the visible upper block |

## Verification
Two events can fall in the same cycle:
- the completion slot and activity on the external interrupt pin;
- the completion slot and a fresh command write.

The bench drives `int1_n_ext` low across the `seq_done` pulse and the cycle after it, with interrupt enable set. It expects the core line to go low for the completion cycle only and then return high while the pin is still low. It also issues a command write during the DONE cycle. It expects no strobe, busy falling on the next cycle, and the register still holding the earlier code.

// File: rtl/flash_iap_pkg.sv
`timescale 1ns/1ps
package flash_iap_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_VERIFY,
        ST_RUN,
        ST_DONE
    } iap_state_e;

    localparam int NUM_OPS        = 6;
    localparam int CODE_W         = 7;
    localparam int OP_BYTE_VERIFY = 3;

    // Strobe bit index -> operation code
    localparam logic [CODE_W-1:0] OP_CODES [NUM_OPS] = '{
        7'h01,   // chip erase
        7'h06,   // burst program
        7'h0B,   // sector erase
        7'h0C,   // byte verify
        7'h0D,   // block erase
        7'h0E    // byte program
    };

endpackage

// File: rtl/iap_cfg_reg.sv
`timescale 1ns/1ps
module iap_cfg_reg #(
    parameter int              ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 8'hB1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        remap_pins,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic              vis_q,
    output logic              iap_en_q,
    output logic [7:0]        cfg_rdata
);

    logic [1:0] map_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vis_q    <= 1'b0;
            iap_en_q <= 1'b0;
            map_q    <= remap_pins;
        end else if (wr_en && addr == CFG_ADDR) begin
            vis_q    <= wdata[7];
            iap_en_q <= wdata[6];
            map_q    <= wdata[1:0];
        end
    end

    assign cfg_rdata = {vis_q, iap_en_q, 4'b0000, map_q};

endmodule

// File: rtl/iap_cmd_decode.sv
`timescale 1ns/1ps
module iap_cmd_decode
    import flash_iap_pkg::*;
(
    input  logic [CODE_W-1:0]  code,
    output logic [NUM_OPS-1:0] op_hit,
    output logic               op_valid,
    output logic               op_short
);

    for (genvar g = 0; g < NUM_OPS; g++) begin : g_match
        assign op_hit[g] = (code == OP_CODES[g]);
    end

    assign op_valid = |op_hit;
    assign op_short = op_hit[OP_BYTE_VERIFY];

endmodule

// File: rtl/iap_seq_fsm.sv
`timescale 1ns/1ps
module iap_seq_fsm
    import flash_iap_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_wr,
    input  logic [7:0]         wdata,
    input  logic               iap_en,
    input  logic [NUM_OPS-1:0] op_hit,
    input  logic               op_valid,
    input  logic               op_short,
    input  logic               seq_done,
    output logic               fie_q,
    output logic [CODE_W-1:0]  code_q,
    output logic [NUM_OPS-1:0] start_q,
    output logic               busy,
    output logic               cmpl
);

    iap_state_e state_q, state_d;
    logic       accept;
    logic       launch;

    assign accept = cmd_wr && (state_q == ST_IDLE);
    assign launch = accept && iap_en && op_valid;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (launch) state_d = op_short ? ST_VERIFY : ST_RUN;
            ST_VERIFY: state_d = ST_IDLE;
            ST_RUN:    if (seq_done) state_d = ST_DONE;
            ST_DONE:   state_d = ST_IDLE;
        endcase
    end

    // Registered outputs: command register and start strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fie_q   <= 1'b0;
            code_q  <= '0;
            start_q <= '0;
        end else begin
            start_q <= launch ? op_hit : '0;
            if (accept) begin
                fie_q  <= wdata[7];
                code_q <= wdata[CODE_W-1:0];
            end
        end
    end

    assign busy = (state_q != ST_IDLE);
    assign cmpl = (state_q == ST_DONE);

endmodule

// File: rtl/iap_irq_steer.sv
`timescale 1ns/1ps
module iap_irq_steer (
    input  logic fie,
    input  logic cmpl,
    input  logic int1_n_ext,
    output logic int1_n_core
);

    assign int1_n_core = fie ? ~cmpl : int1_n_ext;

endmodule

// File: rtl/flash_iap_frontend.sv
`timescale 1ns/1ps
module flash_iap_frontend
    import flash_iap_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] CFG_ADDR = 8'hB1,
    parameter logic [ADDR_W-1:0] CMD_ADDR = 8'hB2,
    parameter int                FETCH_W  = 16,
    parameter int                UPPER_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         remap_pins,
    input  logic [ADDR_W-1:0]  sfr_addr,
    input  logic               sfr_wr,
    input  logic [7:0]         sfr_wdata,
    output logic [7:0]         sfr_rdata,
    output logic [NUM_OPS-1:0] start_vec,
    input  logic               seq_done,
    output logic               busy,
    input  logic               int1_n_ext,
    output logic               int1_n_core,
    input  logic [FETCH_W-1:0] fetch_addr,
    output logic               upper_visible
);

    logic               vis_q, iap_en_q, fie_q, cmpl, op_valid, op_short;
    logic [7:0]         cfg_rdata;
    logic [CODE_W-1:0]  code_q;
    logic [NUM_OPS-1:0] op_hit;
    logic               cmd_wr;

    assign cmd_wr = sfr_wr && (sfr_addr == CMD_ADDR);

    iap_cfg_reg #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_cfg (
        .clk(clk), .rst_n(rst_n), .remap_pins(remap_pins),
        .wr_en(sfr_wr), .addr(sfr_addr), .wdata(sfr_wdata),
        .vis_q(vis_q), .iap_en_q(iap_en_q), .cfg_rdata(cfg_rdata)
    );

    iap_cmd_decode u_dec (
        .code(sfr_wdata[CODE_W-1:0]), .op_hit(op_hit),
        .op_valid(op_valid), .op_short(op_short)
    );

    iap_seq_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .wdata(sfr_wdata),
        .iap_en(iap_en_q), .op_hit(op_hit), .op_valid(op_valid),
        .op_short(op_short), .seq_done(seq_done), .fie_q(fie_q),
        .code_q(code_q), .start_q(start_vec), .busy(busy), .cmpl(cmpl)
    );

    iap_irq_steer u_irq (
        .fie(fie_q), .cmpl(cmpl), .int1_n_ext(int1_n_ext),
        .int1_n_core(int1_n_core)
    );

    always_comb begin
        if (sfr_addr == CFG_ADDR)      sfr_rdata = cfg_rdata;
        else if (sfr_addr == CMD_ADDR) sfr_rdata = {fie_q, code_q};
        else                           sfr_rdata = 8'h00;
    end

    assign upper_visible = vis_q && (&fetch_addr[FETCH_W-1 -: UPPER_W]);

endmodule

// File: rtl/flash_iap_chk.sv
`timescale 1ns/1ps
module flash_iap_chk
    import flash_iap_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_OPS-1:0] start_vec,
    input logic               busy,
    input logic               fie,
    input logic               iap_en,
    input logic               int1_n_ext,
    input logic               int1_n_core
);

    logic past_ok;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(start_vec)); // R3
    AST_START_ONE_WIDE: assert property (@(posedge clk) disable iff (!rst_n)
        (start_vec != '0) |=> (start_vec == '0)); // R3
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_vec != '0) |-> busy); // R6
    AST_NO_START_IAP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(!iap_en)) |-> (start_vec == '0)); // R5
    AST_BUSY_BLOCKS_START: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(busy)) |-> (start_vec == '0)); // R7
    AST_VERIFY_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        start_vec[OP_BYTE_VERIFY] |=> !busy); // R8
    AST_VERIFY_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (start_vec[OP_BYTE_VERIFY] && fie) |=> int1_n_core); // R8
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (fie && !int1_n_core) |=> int1_n_core); // R9
    AST_IRQ_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        (!fie && $stable(fie)) |-> (int1_n_core == int1_n_ext)); // R10

endmodule

bind flash_iap_frontend flash_iap_chk u_chk (
    .clk(clk), .rst_n(rst_n), .start_vec(start_vec), .busy(busy),
    .fie(fie_q), .iap_en(iap_en_q), .int1_n_ext(int1_n_ext),
    .int1_n_core(int1_n_core)
);

// File: tb/flash_iap_frontend_tb.sv
`timescale 1ns/1ps
module flash_iap_frontend_tb;

    localparam logic [7:0] CFG = 8'hB1;
    localparam logic [7:0] CMD = 8'hB2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  remap_pins = 2'b10;
    logic [7:0]  sfr_addr = 8'h00;
    logic        sfr_wr = 1'b0;
    logic [7:0]  sfr_wdata = 8'h00;
    logic [7:0]  sfr_rdata;
    logic [5:0]  start_vec;
    logic        seq_done = 1'b0;
    logic        busy;
    logic        int1_n_ext = 1'b1;
    logic        int1_n_core;
    logic [15:0] fetch_addr = 16'h0000;
    logic        upper_visible;

    int n_cmp = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    flash_iap_frontend u_dut (
        .clk(clk), .rst_n(rst_n), .remap_pins(remap_pins),
        .sfr_addr(sfr_addr), .sfr_wr(sfr_wr), .sfr_wdata(sfr_wdata),
        .sfr_rdata(sfr_rdata), .start_vec(start_vec), .seq_done(seq_done),
        .busy(busy), .int1_n_ext(int1_n_ext), .int1_n_core(int1_n_core),
        .fetch_addr(fetch_addr), .upper_visible(upper_visible)
    );

    // {iap_en, fie, code[6:0], delay[4:0], exp_start[5:0], exp_long}
    localparam int NV = 10;
    localparam logic [20:0] VEC [NV] = '{
        {1'b1, 1'b1, 7'h01, 5'd3, 6'b000001, 1'b1},
        {1'b1, 1'b0, 7'h06, 5'd2, 6'b000010, 1'b1},
        {1'b1, 1'b1, 7'h0B, 5'd5, 6'b000100, 1'b1},
        {1'b1, 1'b1, 7'h0C, 5'd1, 6'b001000, 1'b0},
        {1'b1, 1'b1, 7'h0D, 5'd1, 6'b010000, 1'b1},
        {1'b1, 1'b0, 7'h0E, 5'd4, 6'b100000, 1'b1},
        {1'b1, 1'b1, 7'h00, 5'd1, 6'b000000, 1'b0},
        {1'b1, 1'b1, 7'h7F, 5'd1, 6'b000000, 1'b0},
        {1'b0, 1'b1, 7'h0E, 5'd1, 6'b000000, 1'b0},
        {1'b1, 1'b0, 7'h0F, 5'd1, 6'b000000, 1'b0}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Called at a falling edge; leaves at the next falling edge
    task automatic sfr_write(input logic [7:0] a, input logic [7:0] d);
        sfr_addr  = a;
        sfr_wdata = d;
        sfr_wr    = 1'b1;
        @(negedge clk);
        sfr_wr    = 1'b0;
    endtask

    task automatic sfr_read(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a;
        #1;
        d = sfr_rdata;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++;
        n_err++;
        $display("FAIL watchdog actual=hung expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        remap_pins = 2'b00;

        // R1 reset state
        sfr_read(CFG, rd);     chk("R1 cfg reset", rd, 8'h02);
        sfr_read(CMD, rd);     chk("R1 cmd reset", rd, 8'h00);
        chk("R1 busy reset", busy, 0);
        chk("R1 start reset", start_vec, 0);
        chk("R10 reset pass", int1_n_core, 1);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            logic       v_iap, v_fie, v_long;
            logic [6:0] v_code;
            logic [4:0] v_dly;
            logic [5:0] v_start;
            {v_iap, v_fie, v_code, v_dly, v_start, v_long} = VEC[i];
            sfr_write(CFG, {1'b0, v_iap, 6'b0});
            sfr_write(CMD, {v_fie, v_code});
            chk("R3 strobe", start_vec, v_start);
            chk("R4/R5/R6 busy after write", busy, (v_start != 0));
            if (v_long) begin
                for (int k = 0; k < v_dly; k++) begin
                    @(negedge clk);
                    chk("R3 one wide", start_vec, 0);
                    chk("R6 busy running", busy, 1);
                end
                seq_done = 1'b1;
                @(negedge clk);
                seq_done = 1'b0;
                chk("R6 busy in completion", busy, 1);
                chk("R9 completion irq", int1_n_core, !v_fie);
                @(negedge clk);
                chk("R6 busy falls", busy, 0);
                chk("R9 irq released", int1_n_core, 1);
            end else if (v_start != 0) begin
                @(negedge clk);
                chk("R8 verify busy one cycle", busy, 0);
                chk("R8 verify no irq", int1_n_core, 1);
            end else begin
                @(negedge clk);
                chk("R4/R5 no busy", busy, 0);
            end
        end

        // R2 register fields and readback
        sfr_write(CFG, 8'hFF);
        sfr_read(CFG, rd);     chk("R2 cfg readback", rd, 8'hC3);
        sfr_write(CMD, 8'hFF);
        sfr_read(CMD, rd);     chk("R2 cmd readback", rd, 8'hFF);
        chk("R4 reserved 0x7F no start", start_vec, 0);

        // R11 upper block visibility
        fetch_addr = 16'hF000; #1; chk("R11 F000", upper_visible, 1);
        fetch_addr = 16'hFFFF; #1; chk("R11 FFFF", upper_visible, 1);
        fetch_addr = 16'hEFFF; #1; chk("R11 EFFF", upper_visible, 0);
        @(negedge clk);
        sfr_write(CFG, 8'h40);
        fetch_addr = 16'hF800; #1; chk("R11 hidden", upper_visible, 0);
        @(negedge clk);

        // R10 / R9 steering
        sfr_write(CMD, 8'h00);
        int1_n_ext = 1'b0; #1; chk("R10 pass low", int1_n_core, 0);
        int1_n_ext = 1'b1; #1; chk("R10 pass high", int1_n_core, 1);
        @(negedge clk);
        sfr_write(CMD, 8'h80);
        int1_n_ext = 1'b0; #1; chk("R9 ext masked", int1_n_core, 1);
        int1_n_ext = 1'b1;
        @(negedge clk);

        // R7 write during busy; completion with pin low in the same cycle
        sfr_write(CMD, 8'h8E);
        chk("R3 byte program strobe", start_vec, 6'b100000);
        sfr_write(CMD, 8'h01);
        chk("R7 no strobe while busy", start_vec, 0);
        sfr_read(CMD, rd);     chk("R7 cmd kept", rd, 8'h8E);
        int1_n_ext = 1'b0;
        seq_done   = 1'b1;
        @(negedge clk);
        seq_done   = 1'b0;
        chk("R9 completion with pin low", int1_n_core, 0);
        @(negedge clk);
        chk("R9 pin stays masked", int1_n_core, 1);
        int1_n_ext = 1'b1;

        // R8 verify ignores seq_done
        sfr_write(CMD, 8'h8C);
        chk("R8 verify strobe", start_vec, 6'b001000);
        chk("R8 verify busy", busy, 1);
        seq_done = 1'b1;
        @(negedge clk);
        chk("R8 busy cleared", busy, 0);
        chk("R8 no irq", int1_n_core, 1);
        @(negedge clk);
        seq_done = 1'b0;
        chk("R8 done ignored", busy, 0);

        // R7 write during the completion cycle
        sfr_write(CMD, 8'h0D);
        chk("R3 block erase strobe", start_vec, 6'b010000);
        seq_done = 1'b1;
        @(negedge clk);
        seq_done = 1'b0;
        sfr_write(CMD, 8'h0E);
        chk("R7 no strobe in completion", start_vec, 0);
        chk("R6 busy fell", busy, 0);
        sfr_read(CMD, rd);     chk("R7 cmd kept after completion", rd, 8'h0D);

        // R1 reset with other remap value
        @(negedge clk);
        remap_pins = 2'b01;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        remap_pins = 2'b00;
        @(negedge clk);
        sfr_read(CFG, rd);     chk("R1 remap 01", rd, 8'h01);
        sfr_read(CMD, rd);     chk("R1 cmd cleared", rd, 8'h00);

        finish_run();
    end

endmodule